// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Command Decoder

This block sits behind a serial receiver and turns each complete 16-bit command word into register actions for a two-channel converter. Each channel has a staging (input) register and an output register that drives the converter. A command can write a staging register, copy staging into output for one or both channels, write both outputs at once, or power a channel down. A shutdown keeps all register contents, so the previous output value comes back when the channel is woken.

The three most significant bits of the word form the opcode: bit 15 is the address bit and bits 14:13 are the control pair. The low 13 bits carry the code. When the opcode is 000, bits 12:10 select a subcommand, and bit 9 is the mode value for the subcommand that needs it. A shutdown-enable pin must be high for any shutdown to take effect. A falling edge on that pin wakes both channels. An active-low clear zeroes every staging and output register. The block also holds a general-purpose output bit and a bit that selects the shift edge for an external serial-out stage.

Top module: `dual_dac_cmd_ctrl`

## Requirements
- R1: Opcode 001 writes the 13-bit code field into the staging register of channel A, and opcode 101 writes it into the staging register of channel B. No output register changes.
- R2: Opcode 010 (channel A) or 110 (channel B) writes the code into that channel's staging register. Both output registers then load from their staging registers, and the addressed channel takes the new code.
- R3: Opcode 011 writes the code field directly into both output registers.
- R4: Opcode 100 copies each staging register into its own output register.
- R5: Opcode 111 shuts down both channels, and subcommands 110 (channel A) and 111 (channel B) in bits 12:10 shut down one channel. Each takes effect only while sd_allow is high. Register contents and output codes stay unchanged.
- R6: Any load of a channel's output register clears that channel's shutdown flag.
- R7: A high-to-low transition of sd_allow clears both shutdown flags. The output codes are unchanged.
- R8: Subcommand 001 copies staging A into output A, and subcommand 101 copies staging B into output B.
- R9: Subcommand 010 drives user_out low and 011 drives it high. Subcommand 100 sets dout_mode to bit 9 of the word.
- R10: Subcommand 000 does nothing. A word presented with cmd_valid low changes nothing.
- R11: clr_n low at a clock edge zeroes all four staging and output registers. The shutdown flags, user_out and dout_mode are unchanged.
- R12: After rst_n, all registers are zero, both channels are awake, user_out is 0 and dout_mode is 0.
- R13: A command sampled with cmd_valid high takes effect at that clock edge. dac_upd[i] is high for exactly the following cycle for each channel i whose output register was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| clr_n | input | 1 | Synchronous active-low clear of the code registers |
| sd_allow | input | 1 | Shutdown enable; a falling edge wakes both channels |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Opcode in 15:13, code or subcommand in 12:0 |
| code_a | output | 13 | Output register of channel A |
| code_b | output | 13 | Output register of channel B |
| dac_upd | output | 2 | One-cycle load pulse per channel (bit 0 = A) |
| chan_off | output | 2 | Shutdown flag per channel (bit 0 = A) |
| user_out | output | 1 | General-purpose output bit |
| dout_mode | output | 1 | Serial-out edge select (0 = default) |

## Verification
The bench runs every opcode against six code patterns: all zeros, all ones, two alternating patterns, the top bit alone and the bottom bit alone. Each of these patterns separates one channel from the other, staging from output, and opcodes that differ only in one bit. Every one of the sixteen values of bits 12:9 under opcode 000 is run with the shutdown enable both high and low, so a gated shutdown can be told apart from an ignored one and a don't-care bit 9 from the mode bit. After every command an idle cycle is driven with cmd_valid low and a different word on the bus. This shows that the update pulse ends and that a word without the strobe is ignored. Dedicated sequences cover wake by enable fall, wake by output load, and clear.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;

    parameter int CODE_W = 13;

    typedef enum logic [2:0] {
        OP_SUB        = 3'd0,
        OP_STAGE_A    = 3'd1,
        OP_STAGE_A_GO = 3'd2,
        OP_DIRECT_ALL = 3'd3,
        OP_COPY_ALL   = 3'd4,
        OP_STAGE_B    = 3'd5,
        OP_STAGE_B_GO = 3'd6,
        OP_SLEEP_ALL  = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        SUB_NOP     = 3'd0,
        SUB_COPY_A  = 3'd1,
        SUB_USR_LO  = 3'd2,
        SUB_USR_HI  = 3'd3,
        SUB_MODE    = 3'd4,
        SUB_COPY_B  = 3'd5,
        SUB_SLEEP_A = 3'd6,
        SUB_SLEEP_B = 3'd7
    } subcmd_e;

    typedef struct packed {
        logic [1:0] stage_wr;
        logic [1:0] copy_req;
        logic [1:0] direct_wr;
        logic [1:0] sleep_req;
        logic       usr_we;
        logic       usr_val;
        logic       mode_we;
        logic       mode_val;
    } action_t;

endpackage

// File: rtl/dual_dac_decode.sv
module dual_dac_decode
    import dual_dac_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          valid,
    input  logic [CW+2:0] word,
    output action_t       act
);

    opcode_e opc;
    subcmd_e sub;
    logic    sub_bit;

    always_comb begin
        opc     = opcode_e'(word[CW+2:CW]);
        sub     = subcmd_e'(word[CW-1 -: 3]);
        sub_bit = word[CW-4];
        act     = '0;
        if (valid) begin
            unique case (opc)
                OP_STAGE_A:    act.stage_wr = 2'b01;
                OP_STAGE_B:    act.stage_wr = 2'b10;
                OP_STAGE_A_GO: begin
                    act.stage_wr = 2'b01;
                    act.copy_req = 2'b11;
                end
                OP_STAGE_B_GO: begin
                    act.stage_wr = 2'b10;
                    act.copy_req = 2'b11;
                end
                OP_DIRECT_ALL: act.direct_wr = 2'b11;
                OP_COPY_ALL:   act.copy_req  = 2'b11;
                OP_SLEEP_ALL:  act.sleep_req = 2'b11;
                OP_SUB: begin
                    unique case (sub)
                        SUB_COPY_A:  act.copy_req  = 2'b01;
                        SUB_COPY_B:  act.copy_req  = 2'b10;
                        SUB_SLEEP_A: act.sleep_req = 2'b01;
                        SUB_SLEEP_B: act.sleep_req = 2'b10;
                        SUB_USR_LO: begin
                            act.usr_we  = 1'b1;
                            act.usr_val = 1'b0;
                        end
                        SUB_USR_HI: begin
                            act.usr_we  = 1'b1;
                            act.usr_val = 1'b1;
                        end
                        SUB_MODE: begin
                            act.mode_we  = 1'b1;
                            act.mode_val = sub_bit;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dual_dac_channel.sv
module dual_dac_channel #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          stage_wr,
    input  logic          copy_req,
    input  logic          direct_wr,
    input  logic          sleep_req,
    input  logic          sd_allow,
    input  logic          wake,
    input  logic [CW-1:0] data,
    output logic [CW-1:0] dac_code,
    output logic          dac_upd,
    output logic          off
);

    typedef struct packed {
        logic [CW-1:0] stage;
        logic [CW-1:0] dac;
        logic          upd;
        logic          off;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     out_wr;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        out_wr   = direct_wr | copy_req;
        if (stage_wr)
            st_d.stage = data;
        if (direct_wr)
            st_d.dac = data;
        else if (copy_req)
            st_d.dac = stage_wr ? data : st_q.stage;
        if (out_wr)
            st_d.upd = 1'b1;
        if (!clr_n) begin
            st_d.stage = '0;
            st_d.dac   = '0;
            st_d.upd   = 1'b0;
        end
        if (wake || (out_wr && clr_n))
            st_d.off = 1'b0;
        else if (sleep_req && sd_allow)
            st_d.off = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dac_code = st_q.dac;
    assign dac_upd  = st_q.upd;
    assign off      = st_q.off;

    // R13: the output code only moves with a load pulse or after a clear
    assert_code_moves_with_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> (dac_upd || $past(!clr_n)));

    // R5: a refused shutdown leaves an awake channel awake
    assert_lockout_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !sd_allow && !off) |=> !off);

    // R1: a staging-only write never disturbs the output code
    assert_stage_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_wr && !copy_req && !direct_wr && clr_n) |=> $stable(dac_code));

    // R11: a clear leaves a zero output code
    assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (dac_code == '0));

endmodule

// File: rtl/dual_dac_cmd_ctrl.sv
module dual_dac_cmd_ctrl
    import dual_dac_pkg::*;
#(
    parameter int CW    = CODE_W,
    parameter int NCHAN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             sd_allow,
    input  logic             cmd_valid,
    input  logic [CW+2:0]    cmd_word,
    output logic [CW-1:0]    code_a,
    output logic [CW-1:0]    code_b,
    output logic [NCHAN-1:0] dac_upd,
    output logic [NCHAN-1:0] chan_off,
    output logic             user_out,
    output logic             dout_mode
);

    typedef struct packed {
        logic allow_prev;
        logic user;
        logic mode;
    } misc_st_t;

    misc_st_t      ms_d, ms_q;
    action_t       act;
    logic          wake;
    logic [CW-1:0] code_arr [NCHAN];

    dual_dac_decode #(.CW(CW)) decode_i (
        .valid (cmd_valid),
        .word  (cmd_word),
        .act   (act)
    );

    always_comb begin
        ms_d            = ms_q;
        ms_d.allow_prev = sd_allow;
        wake            = ms_q.allow_prev & ~sd_allow;
        if (act.usr_we)
            ms_d.user = act.usr_val;
        if (act.mode_we)
            ms_d.mode = act.mode_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ms_q <= '0;
        else
            ms_q <= ms_d;
    end

    for (genvar i = 0; i < NCHAN; i++) begin : g_chan
        dual_dac_channel #(.CW(CW)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_n     (clr_n),
            .stage_wr  (act.stage_wr[i]),
            .copy_req  (act.copy_req[i]),
            .direct_wr (act.direct_wr[i]),
            .sleep_req (act.sleep_req[i]),
            .sd_allow  (sd_allow),
            .wake      (wake),
            .data      (cmd_word[CW-1:0]),
            .dac_code  (code_arr[i]),
            .dac_upd   (dac_upd[i]),
            .off       (chan_off[i])
        );
    end

    assign code_a    = code_arr[0];
    assign code_b    = code_arr[1];
    assign user_out  = ms_q.user;
    assign dout_mode = ms_q.mode;

    // R7: a falling shutdown enable leaves both channels awake
    assert_enable_fall_wakes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_allow) |=> (chan_off == '0));

    // R10: without a strobe nothing pulses and the mode bits hold
    assert_idle_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (dac_upd == '0) && $stable(user_out) && $stable(dout_mode));

endmodule

// File: tb/dual_dac_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module dual_dac_cmd_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1;
    logic        sd_allow = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [12:0] code_a, code_b;
    logic [1:0]  dac_upd, chan_off;
    logic        user_out, dout_mode;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // reference state, built from the requirements
    logic [12:0] m_stg_a = '0, m_stg_b = '0, m_dac_a = '0, m_dac_b = '0;
    logic [1:0]  m_upd = '0, m_off = '0;
    logic        m_user = 1'b0, m_mode = 1'b0;

    always #5 clk = ~clk;

    dual_dac_cmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sd_allow(sd_allow),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .code_a(code_a), .code_b(code_b), .dac_upd(dac_upd),
        .chan_off(chan_off), .user_out(user_out), .dout_mode(dout_mode)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "code_a",    {3'b0, code_a},    {3'b0, m_dac_a});
        check(tag, "code_b",    {3'b0, code_b},    {3'b0, m_dac_b});
        check(tag, "dac_upd",   {14'b0, dac_upd},  {14'b0, m_upd});
        check(tag, "chan_off",  {14'b0, chan_off}, {14'b0, m_off});
        check(tag, "user_out",  {15'b0, user_out}, {15'b0, m_user});
        check(tag, "dout_mode", {15'b0, dout_mode}, {15'b0, m_mode});
    endtask

    function automatic string tag_of(input logic [15:0] w);
        case (w[15:13])
            3'd1, 3'd5: return "R1";
            3'd2, 3'd6: return "R2";
            3'd3:       return "R3";
            3'd4:       return "R4";
            3'd7:       return "R5";
            default:
                case (w[12:10])
                    3'd1, 3'd5: return "R8";
                    3'd6, 3'd7: return "R5";
                    3'd2, 3'd3, 3'd4: return "R9";
                    default: return "R10";
                endcase
        endcase
    endfunction

    task automatic model_apply(input logic [15:0] w);
        logic [12:0] d;
        d = w[12:0];
        m_upd = 2'b00;
        case (w[15:13])
            3'd1: m_stg_a = d;
            3'd5: m_stg_b = d;
            3'd2, 3'd6: begin
                if (w[15]) m_stg_b = d; else m_stg_a = d;
                m_dac_a = m_stg_a; m_dac_b = m_stg_b; m_upd = 2'b11; m_off = 2'b00;
            end
            3'd3: begin m_dac_a = d; m_dac_b = d; m_upd = 2'b11; m_off = 2'b00; end
            3'd4: begin m_dac_a = m_stg_a; m_dac_b = m_stg_b; m_upd = 2'b11; m_off = 2'b00; end
            3'd7: if (sd_allow) m_off = 2'b11;
            default:
                case (w[12:10])
                    3'd1: begin m_dac_a = m_stg_a; m_upd[0] = 1'b1; m_off[0] = 1'b0; end
                    3'd5: begin m_dac_b = m_stg_b; m_upd[1] = 1'b1; m_off[1] = 1'b0; end
                    3'd6: if (sd_allow) m_off[0] = 1'b1;
                    3'd7: if (sd_allow) m_off[1] = 1'b1;
                    3'd2: m_user = 1'b0;
                    3'd3: m_user = 1'b1;
                    3'd4: m_mode = w[9];
                    default: ;
                endcase
        endcase
    endtask

    // R13: result visible one edge after the strobe, pulse gone the cycle after
    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_word  = w;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = ~w;
        model_apply(w);
        compare_all(tag_of(w));
        @(negedge clk);
        m_upd = 2'b00;
        compare_all("R13");
    endtask

    task automatic set_allow(input logic v);
        logic fell;
        @(negedge clk);
        fell = sd_allow & ~v;
        sd_allow = v;
        @(negedge clk);
        if (fell) m_off = 2'b00;
        compare_all("R7");
    endtask

    initial begin
        logic [12:0] pats [6];
        pats[0] = 13'h0000; pats[1] = 13'h1FFF; pats[2] = 13'h1555;
        pats[3] = 13'h0AAA; pats[4] = 13'h1000; pats[5] = 13'h0001;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R12");

        // every opcode against every pattern
        for (int op = 0; op < 8; op++)
            for (int p = 0; p < 6; p++)
                send({op[2:0], pats[p]});

        // every subcommand value, enable high and then low
        for (int al = 1; al >= 0; al--) begin
            set_allow(al[0]);
            send(16'h6ABC);
            for (int s = 0; s < 16; s++)
                send({3'b000, s[3:0], 9'h1A5 ^ 9'(s * 37)});
        end
        set_allow(1'b1);

        // R5 and R7: shut down both, values held, enable fall wakes both
        send({3'd2, 13'h0123});
        send({3'd7, 13'h1FFF});
        check("R5", "off both", {14'b0, chan_off}, 16'h0003);
        set_allow(1'b0);
        check("R7", "woken",    {14'b0, chan_off}, 16'h0000);
        check("R7", "code kept", {3'b0, code_a}, 16'h0123);
        set_allow(1'b1);

        // R6: a direct output load wakes a sleeping channel
        send({3'b000, 3'd7, 10'h000});
        check("R6", "B asleep", {14'b0, chan_off}, 16'h0002);
        send({3'd3, 13'h0777});
        check("R6", "B awake",  {14'b0, chan_off}, 16'h0000);

        // R11: clear zeroes codes and staging, flags untouched
        send({3'b000, 3'd6, 10'h000});
        send({3'd1, 13'h1234});
        send({3'b000, 3'd3, 10'h000});
        @(negedge clk);
        clr_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        m_stg_a = '0; m_stg_b = '0; m_dac_a = '0; m_dac_b = '0;
        compare_all("R11");
        send({3'd4, 13'h0000});
        check("R11", "staging cleared", {3'b0, code_a}, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule